// File: doc/BRIEF.md
# Configurable GPIO Port with Merged Interrupt

This block controls a bank of general-purpose pins from a small register bus. Each pin can be an input or an output on its own. Three registers set it up: an output latch, a direction mask and a per-pin option mask. On an input pin the option bit turns interrupt reporting on. On an output pin the option bit picks open-drain drive instead of push-pull. The block does not contain pad cells. It produces a value and an output-enable for each pin, and the pads are placed outside it.

On-chip peripherals can take over a pin as an output. In that case they supply the pin value and choose between push-pull and open-drain drive. That takeover wins over the register settings. Peripherals that use a pin as an input get the synchronized pin levels on a separate bus. Those same levels stay readable through the data register.

All pins that are enabled for interrupts share one line. The line is high only while every enabled pin is high. Edge or level detection is applied to that shared line, so any enabled pin that stays low hides events on the other pins. The sensitivity comes in on a 2-bit input.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, option and latch registers read 0, every output-enable is 0 and the interrupt request is 0.
- R2: A pin with direction bit 0 is never driven by the registers. A pin with direction bit 1 and option bit 0 drives its latch value with output-enable 1.
- R3: Register addresses are data = 0, direction = 1, option = 2. Address 3 reads 0. Bit N of every register belongs to pin N.
- R4: Reading address 0 returns, for each pin, the latch value if its direction bit is 1 and the synchronized pin level if its direction bit is 0. A pin change is visible after two clock edges.
- R5: A write to address 0 updates the latch even while the pin is an input. The written value appears on the pad as soon as the direction bit is set.
- R6: Only pins that have option bit 1 and direction bit 0 feed the interrupt. Output pins and pins with option bit 0 never cause a request.
- R7: The sensitivity codes are: 00 = request held while the line is low; 01 = rising edge; 10 = falling edge; 11 = either edge. An edge request is a one-cycle pulse on the third clock edge after the pin changes. In rising-edge mode a request is never followed directly by another request.
- R8: The shared line is the AND of the enabled pins. While one enabled pin is low, edges on the other enabled pins cause no request.
- R9: An output pin with option bit 1 is open-drain. Its output-enable is 1 only while the latch is 0.
- R10: A pin whose alternate-output enable is 1 drives the peripheral's value, whatever the direction and latch say. Its output-enable is 1, except when the peripheral asks for open-drain and the value is 1.
- R11: The alternate-input bus carries the synchronized level of every pin. A peripheral takeover does not change what address 0 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data for reg_addr, combinational |
| irq_sense | input | 2 | Interrupt sensitivity code |
| pad_in | input | NPINS | Levels arriving from the pads |
| pad_out | output | NPINS | Value sent to each pad |
| pad_oe | output | NPINS | Output-enable for each pad |
| alt_out_en | input | NPINS | Peripheral takes the pin as an output |
| alt_out_val | input | NPINS | Peripheral output value |
| alt_out_od | input | NPINS | Peripheral asks for open-drain drive |
| alt_in | output | NPINS | Synchronized pin levels sent to peripherals |
| irq_req | output | 1 | Shared interrupt request |

## Verification
The bench uses the default NPINS = 8 and SYNC_STAGES = 2. With these values the two-edge readback delay and the three-edge interrupt delay can be checked at exact cycles. A single byte pattern can mix input pins, push-pull outputs, open-drain outputs and peripheral-owned pins at the same time. Eight pins also leave room to keep one enabled pin low while another toggles, and to toggle unmasked and output pins at the same moment. That exercises the masking rules against each other.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DATA = 2'd0,
        ADDR_DIR  = 2'd1,
        ADDR_OPT  = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] lat,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] opt,
    input  logic [NPINS-1:0] alt_en,
    input  logic [NPINS-1:0] alt_val,
    input  logic [NPINS-1:0] alt_od,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic val, od, drv;
        always_comb begin
            if (alt_en[i]) begin
                val = alt_val[i];
                od  = alt_od[i];
                drv = 1'b1;
            end else begin
                val = lat[i];
                od  = opt[i];
                drv = dir[i];
            end
        end
        assign pad_out[i] = val;
        assign pad_oe[i]  = drv & (~od | ~val);
    end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_s,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] opt,
    input  logic [1:0]       sense,
    output logic             irq
);
    typedef struct packed {
        logic line;
        logic irq;
    } st_t;

    st_t st_d, st_q;
    logic [NPINS-1:0] mask;
    logic             line;

    assign mask = opt & ~dir;
    assign line = &(pin_s | ~mask);

    always_comb begin
        st_d      = st_q;
        st_d.line = line;
        case (sense_e'(sense))
            SENSE_LOW:  st_d.irq = ~line;
            SENSE_RISE: st_d.irq = line & ~st_q.line;
            SENSE_FALL: st_d.irq = ~line & st_q.line;
            default:    st_d.irq = line ^ st_q.line;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line <= 1'b1;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [1:0]        irq_sense,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  alt_out_en,
    input  logic [NPINS-1:0]  alt_out_val,
    input  logic [NPINS-1:0]  alt_out_od,
    output logic [NPINS-1:0]  alt_in,
    output logic              irq_req
);
    typedef struct packed {
        logic [NPINS-1:0] lat;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] opt;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NPINS-1:0] pin_s;

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            case (addr_e'(reg_addr))
                ADDR_DATA: regs_d.lat = reg_wdata;
                ADDR_DIR:  regs_d.dir = reg_wdata;
                ADDR_OPT:  regs_d.opt = reg_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr_e'(reg_addr))
            ADDR_DATA: reg_rdata = (regs_q.lat & regs_q.dir) | (pin_s & ~regs_q.dir);
            ADDR_DIR:  reg_rdata = regs_q.dir;
            ADDR_OPT:  reg_rdata = regs_q.opt;
            default:   reg_rdata = '0;
        endcase
    end

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_s)
    );

    gpio_drive #(.NPINS(NPINS)) u_drive (
        .lat     (regs_q.lat),
        .dir     (regs_q.dir),
        .opt     (regs_q.opt),
        .alt_en  (alt_out_en),
        .alt_val (alt_out_val),
        .alt_od  (alt_out_od),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    gpio_irq #(.NPINS(NPINS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_s (pin_s),
        .dir   (regs_q.dir),
        .opt   (regs_q.opt),
        .sense (irq_sense),
        .irq   (irq_req)
    );

    assign alt_in = pin_s;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] dir,
    input logic [NPINS-1:0] opt,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] alt_out_en,
    input logic [NPINS-1:0] alt_out_val,
    input logic [NPINS-1:0] alt_out_od,
    input logic [1:0]       irq_sense,
    input logic             irq_req
);
    // R2: register-owned input pins are never driven
    a_r2_input_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ((~alt_out_en & ~dir & pad_oe) == '0));

    // R10: peripheral value reaches the pad
    a_r10_alt_value: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt_out_en & (pad_out ^ alt_out_val)) == '0));

    // R10: peripheral push-pull pins are driven
    a_r10_alt_pushpull: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt_out_en & ~alt_out_od & ~pad_oe) == '0));

    // R10: peripheral open-drain high is released
    a_r10_alt_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt_out_en & alt_out_od & alt_out_val & pad_oe) == '0));

    // R6: no enabled pins for two cycles means no request
    a_r6_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(opt & ~dir) == '0) && ($past(opt & ~dir, 2) == '0)) |-> !irq_req);

    // R7: rising-edge requests never come back to back
    a_r7_rise_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_sense == 2'b01) |=> !irq_req);
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir         (regs_q.dir),
    .opt         (regs_q.opt),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .alt_out_en  (alt_out_en),
    .alt_out_val (alt_out_val),
    .alt_out_od  (alt_out_od),
    .irq_sense   (irq_sense),
    .irq_req     (irq_req)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] irq_sense = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, alt_in;
    logic [7:0] alt_out_en = '0, alt_out_val = '0, alt_out_od = '0;
    logic       irq_req;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_sense(irq_sense),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_out_en(alt_out_en), .alt_out_val(alt_out_val), .alt_out_od(alt_out_od),
        .alt_in(alt_in), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 data", 2'd0, 8'h00);
        rd_chk("R1 dir", 2'd1, 8'h00);
        rd_chk("R1 opt", 2'd2, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_readback;
        pad_in = 8'hA5;
        step(1);
        step(1);
        rd_chk("R4 input level after two edges", 2'd0, 8'hA5);
        chk("R11 alt_in", alt_in, 8'hA5);
        wr(2'd0, 8'h3C);
        rd_chk("R5 latch hidden while input", 2'd0, 8'hA5);
        chk("R2 input not driven", pad_oe, 8'h00);
        rd_chk("R3 unused address", 2'd3, 8'h00);
    endtask

    task automatic t_output;
        wr(2'd1, 8'hFF);
        chk("R5 latch on pad", pad_out, 8'h3C);
        chk("R2 push-pull oe", pad_oe, 8'hFF);
        rd_chk("R4 output reads latch", 2'd0, 8'h3C);
        wr(2'd1, 8'h0F);
        rd_chk("R4 mixed readback", 2'd0, 8'hAC);
        rd_chk("R3 dir readback", 2'd1, 8'h0F);
        wr(2'd2, 8'h0F);
        rd_chk("R3 opt readback", 2'd2, 8'h0F);
        chk("R9 open-drain oe", pad_oe, 8'h03);
        chk("R9 open-drain value", pad_out, 8'h3C);
    endtask

    task automatic t_alt;
        alt_out_en = 8'hF0; alt_out_val = 8'h50; alt_out_od = 8'hC0;
        #1;
        chk("R10 alt value", pad_out, 8'h5C);
        chk("R10 alt drive", pad_oe, 8'hB3);
        rd_chk("R11 readback unchanged", 2'd0, 8'hAC);
        chk("R11 alt_in", alt_in, 8'hA5);
        step(1);
        alt_out_en = '0; alt_out_val = '0; alt_out_od = '0;
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
    endtask

    task automatic expect_pulse(input string req);
        step(2);
        chk({req, " quiet before third edge"}, {7'd0, irq_req}, 8'h00);
        step(1);
        chk({req, " pulse"}, {7'd0, irq_req}, 8'h01);
        step(1);
        chk({req, " pulse ends"}, {7'd0, irq_req}, 8'h00);
    endtask

    task automatic expect_quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            seen |= int'(irq_req);
        end
        chk(req, 8'(seen), 8'h00);
    endtask

    task automatic t_irq_rise;
        pad_in = 8'hFF;
        step(3);
        wr(2'd2, 8'h0F);
        irq_sense = 2'b01;
        step(3);
        chk("R6 idle no request", {7'd0, irq_req}, 8'h00);
        pad_in[0] = 1'b0;
        expect_quiet("R7 falling ignored in rise mode", 5);
        pad_in[0] = 1'b1;
        expect_pulse("R7 rise");
        pad_in[1] = 1'b0;
        step(4);
        pad_in[0] = 1'b0;
        step(3);
        pad_in[0] = 1'b1;
        expect_quiet("R8 low pin masks others", 6);
        pad_in[1] = 1'b1;
        expect_pulse("R8 release gives rise");
    endtask

    task automatic t_irq_mask;
        irq_sense = 2'b10;
        wr(2'd1, 8'h04);
        step(2);
        pad_in[2] = 1'b0;
        pad_in[4] = 1'b0;
        expect_quiet("R6 output and unmasked pins ignored", 6);
        pad_in = 8'hFF;
        step(3);
        wr(2'd1, 8'h00);
        step(3);
    endtask

    task automatic t_irq_modes;
        irq_sense = 2'b10;
        step(2);
        pad_in[3] = 1'b0;
        expect_pulse("R7 fall");
        irq_sense = 2'b11;
        step(1);
        pad_in[3] = 1'b1;
        expect_pulse("R7 both rise");
        pad_in[3] = 1'b0;
        expect_pulse("R7 both fall");
        pad_in[3] = 1'b1;
        step(4);
        irq_sense = 2'b00;
        step(2);
        chk("R7 level idle", {7'd0, irq_req}, 8'h00);
        pad_in[3] = 1'b0;
        step(3);
        chk("R7 level asserted", {7'd0, irq_req}, 8'h01);
        step(3);
        chk("R7 level held", {7'd0, irq_req}, 8'h01);
        pad_in[3] = 1'b1;
        step(2);
        chk("R7 level held until line rises", {7'd0, irq_req}, 8'h01);
        step(1);
        chk("R7 level released", {7'd0, irq_req}, 8'h00);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_readback();
        t_output();
        t_alt();
        t_irq_rise();
        t_irq_mask();
        t_irq_modes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule